// File: doc/BRIEF.md
# DTMF Steering and Output Latch

This block sits behind a dual-tone detector and decides which detected key presses count as real digits. The detector reports a tone-present flag together with a 2-bit row index and a 2-bit column index. The block times how long each tone lasts and how long each silence between tones lasts. It counts in ticks from an internal prescaler, so a tick is one millisecond at the intended clock. A tone that lasts long enough is encoded into a 4-bit digit code and stored in an output latch. A flag then tells the host that a new code is waiting.

An early-steering flag follows the qualified tone-present input with one register of delay. A delayed-steering flag rises only after a tone has been held for the presence guard time. It falls only after the tone has been absent for the absence guard time. Short dropouts inside one key press are therefore bridged, and one long press gives exactly one registered digit. The code drives a 4-bit bus that floats when output-enable is low. An inhibit input blocks new detection. A power-down input clears all timing state but keeps the last code.

Top module: `dtmf_steer`

## Requirements
- R1: `early_steer` equals `tone_valid` AND NOT `inhibit` AND NOT `pwrdn` as sampled at the previous clock edge. It drops one clock after any loss of the tone.
- R2: The latch is written once the tone has stayed present for `PRES_TICKS` consecutive ticks (default 30). `delayed_steer` rises one clock after the latch write.
- R3: With default parameters and a tick of `TICK_CLKS` clocks, a tone of 20 ticks or less is not registered: the latch keeps its value and `delayed_steer` stays low. A tone of 35 ticks or more is registered.
- R4: While `delayed_steer` is high, a gap of 20 ticks or less does not lower it. A tone that follows such a gap does not rewrite the latch, even when it is a different key.
- R5: `delayed_steer` falls only after `ABS_TICKS` consecutive tone-absent ticks (default 30), so a gap of 40 ticks or more releases it. After the release, the next qualified tone is registered.
- R6: Row index 0..3 stands for 697/770/852/941 Hz and column index 0..3 for 1209/1336/1477/1633 Hz. The code map is as follows. Keys 1 to 9 (rows 0..2, columns 0..2) give row*3+col+1. Row 3 gives 1011 for column 0, 1010 for column 1 and 1100 for column 2. Column 3 gives 1101, 1110 and 1111 for rows 0, 1 and 2, and 0000 for row 3.
- R7: When `oe` is high, `code_bus` shows the latched code. That code has already been on the bus for at least one clock when `delayed_steer` rises, and it stays there until the next registered tone.
- R8: When `oe` is low, all four lines of `code_bus` are high impedance.
- R9: While `inhibit` is high, `early_steer` stays low and no tone is registered, however long it lasts.
- R10: One clock after `pwrdn` is high, both steering flags are low and both guard timers are cleared. The latched code is kept. After `pwrdn` is released, a tone still present must be timed again from zero.
- R11: After reset, both steering flags are low and the latched code is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tone_valid | input | 1 | Detector reports a recognisable tone pair |
| row_idx | input | 2 | Low-group tone index from the detector |
| col_idx | input | 2 | High-group tone index from the detector |
| inhibit | input | 1 | High blocks detection of new tones |
| pwrdn | input | 1 | High puts the block in standby |
| oe | input | 1 | High drives the code bus, low floats it |
| early_steer | output | 1 | Registered, qualified tone-present flag |
| delayed_steer | output | 1 | A guarded digit is held in the latch |
| code_bus | output | 4 | Tri-state latched digit code |

## Verification
A table walks all sixteen row/column pairs, each pressed for 40 ms and released for 45 ms. This tells apart every entry of the non-binary code map. It also shows that a long press is registered and that a long gap releases the flag. A 20 ms press and a 35 ms press sit on either side of the presence guard, separating rejection from acceptance. A press, a 10 ms gap and a different key, with no fall of `delayed_steer` and no latch rewrite, tells pause bridging apart from a new digit. Inhibit, power-down with the tone still held, and output-enable low over a zero code read against bench pull-ups each separate one control path from the normal timing.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CAPT = 2'd1,
    ST_ARM  = 2'd2,
    ST_HOLD = 2'd3
  } steer_state_e;

  localparam int IDX_W  = 2;
  localparam int CODE_W = 4;

  // Keypad position to output code; see R6 in the brief for the mapping.
  function automatic logic [CODE_W-1:0] key_code(input logic [IDX_W-1:0] r,
                                                 input logic [IDX_W-1:0] c);
    logic [CODE_W-1:0] res;
    if (c == 2'd3) begin
      res = (r == 2'd3) ? 4'd0 : 4'(4'd13 + {2'b00, r});
    end else if (r == 2'd3) begin
      case (c)
        2'd0:    res = 4'd11;
        2'd1:    res = 4'd10;
        default: res = 4'd12;
      endcase
    end else begin
      res = 4'({2'b00, r} * 4'd3 + {2'b00, c} + 4'd1);
    end
    return res;
  endfunction

endpackage

// File: rtl/dtmf_tick_gen.sv
module dtmf_tick_gen #(
  parameter int TICK_CLKS = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int CW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CLKS - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
      tick  <= 1'b0;
    end else if (div_q == LAST) begin
      div_q <= '0;
      tick  <= 1'b1;
    end else begin
      div_q <= div_q + 1'b1;
      tick  <= 1'b0;
    end
  end

  generate
    if (TICK_CLKS > 1) begin : g_spacing
      // R3
      tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/dtmf_digit_map.sv
module dtmf_digit_map
  import dtmf_steer_pkg::*;
(
  input  logic [IDX_W-1:0]  row,
  input  logic [IDX_W-1:0]  col,
  output logic [CODE_W-1:0] code
);
  always_comb code = key_code(row, col);
endmodule

// File: rtl/dtmf_guard_fsm.sv
module dtmf_guard_fsm
  import dtmf_steer_pkg::*;
#(
  parameter int PRES_TICKS = 30,
  parameter int ABS_TICKS  = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic pwrdn,
  input  logic tick,
  input  logic tone_on,
  output logic capture,
  output logic dsteer
);
  localparam int MAXT = (PRES_TICKS > ABS_TICKS) ? PRES_TICKS : ABS_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] PRES_LAST = TW'(PRES_TICKS - 1);
  localparam logic [TW-1:0] ABS_LAST  = TW'(ABS_TICKS - 1);

  steer_state_e state_q;
  logic [TW-1:0] pres_cnt, abs_cnt;

  assign capture = (state_q == ST_CAPT);

  always_ff @(posedge clk) begin
    if (rst || pwrdn) begin
      state_q  <= ST_IDLE;
      pres_cnt <= '0;
      abs_cnt  <= '0;
      dsteer   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (!tone_on) begin
            pres_cnt <= '0;
          end else if (tick) begin
            if (pres_cnt == PRES_LAST) begin
              pres_cnt <= '0;
              state_q  <= ST_CAPT;
            end else begin
              pres_cnt <= pres_cnt + 1'b1;
            end
          end
        end
        ST_CAPT: state_q <= ST_ARM;
        ST_ARM: begin
          dsteer  <= 1'b1;
          abs_cnt <= '0;
          state_q <= ST_HOLD;
        end
        default: begin
          if (tone_on) begin
            abs_cnt <= '0;
          end else if (tick) begin
            if (abs_cnt == ABS_LAST) begin
              abs_cnt <= '0;
              dsteer  <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              abs_cnt <= abs_cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  // R5
  release_on_absence_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dsteer) |-> ($past(pwrdn) || !$past(tone_on)));

  // R10
  pwrdn_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pwrdn) |-> (!dsteer && pres_cnt == '0 && abs_cnt == '0));

  // R2
  pres_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pres_cnt <= PRES_LAST);

  // R4
  abs_bound_chk: assert property (@(posedge clk) disable iff (rst)
    abs_cnt <= ABS_LAST);

endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
  import dtmf_steer_pkg::*;
#(
  parameter int TICK_CLKS  = 50000,
  parameter int PRES_TICKS = 30,
  parameter int ABS_TICKS  = 30
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tone_valid,
  input  logic [1:0] row_idx,
  input  logic [1:0] col_idx,
  input  logic       inhibit,
  input  logic       pwrdn,
  input  logic       oe,
  output logic       early_steer,
  output logic       delayed_steer,
  output logic [3:0] code_bus
);
  logic              tick;
  logic              capture;
  logic [IDX_W-1:0]  row_q, col_q;
  logic [CODE_W-1:0] enc_code, code_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      early_steer <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      code_q      <= '0;
    end else begin
      early_steer <= tone_valid & ~inhibit & ~pwrdn;
      row_q       <= row_idx;
      col_q       <= col_idx;
      if (capture) code_q <= enc_code;
    end
  end

  dtmf_tick_gen #(.TICK_CLKS(TICK_CLKS)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (pwrdn),
    .tick (tick)
  );

  dtmf_digit_map u_map (
    .row  (row_q),
    .col  (col_q),
    .code (enc_code)
  );

  dtmf_guard_fsm #(.PRES_TICKS(PRES_TICKS), .ABS_TICKS(ABS_TICKS)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .pwrdn   (pwrdn),
    .tick    (tick),
    .tone_on (early_steer),
    .capture (capture),
    .dsteer  (delayed_steer)
  );

  assign code_bus = oe ? code_q : 4'bzzzz;

  // R7
  code_settled_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(delayed_steer) |-> $stable(code_q));

  // R2
  latch_then_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(code_q) |=> (delayed_steer || $past(pwrdn)));

  // R9
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(inhibit) |-> !early_steer);

endmodule

// File: tb/dtmf_steer_test.sv
module dtmf_steer_test;
  localparam int TICK = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tone_valid = 1'b0;
  logic [1:0] row_idx = '0, col_idx = '0;
  logic inhibit = 1'b0, pwrdn = 1'b0, oe = 1'b1;
  logic early_steer, delayed_steer;
  wire  [3:0] code_bus;

  pullup (code_bus[0]);
  pullup (code_bus[1]);
  pullup (code_bus[2]);
  pullup (code_bus[3]);

  int checks = 0, fails = 0, rises = 0, falls = 0;
  bit done = 1'b0;
  logic prev_ds = 1'b0;
  logic [3:0] prev_bus = '0;

  // {row, col, expected code} per R6
  localparam logic [7:0] VEC [16] = '{
    8'h01, 8'h12, 8'h23, 8'h3D,
    8'h44, 8'h55, 8'h66, 8'h7E,
    8'h87, 8'h98, 8'hA9, 8'hBF,
    8'hCB, 8'hDA, 8'hEC, 8'hF0
  };

  dtmf_steer #(.TICK_CLKS(TICK), .PRES_TICKS(30), .ABS_TICKS(30)) uut (
    .clk(clk), .rst(rst), .tone_valid(tone_valid), .row_idx(row_idx),
    .col_idx(col_idx), .inhibit(inhibit), .pwrdn(pwrdn), .oe(oe),
    .early_steer(early_steer), .delayed_steer(delayed_steer),
    .code_bus(code_bus)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic ms(input int n);
    cyc(n * TICK);
  endtask

  task automatic press(input logic [1:0] r, input logic [1:0] c, input int dur);
    row_idx = r; col_idx = c; tone_valid = 1'b1;
    ms(dur);
  endtask

  task automatic release_for(input int dur);
    tone_valid = 1'b0;
    ms(dur);
  endtask

  // R7: bus already holds the new code in the cycle before delayed_steer rises
  always @(negedge clk) begin
    if (!rst) begin
      if (delayed_steer && !prev_ds) begin
        rises++;
        if (oe) chk("R7 code settled before flag", prev_bus, code_bus);
      end
      if (!delayed_steer && prev_ds) falls++;
      prev_ds  = delayed_steer;
      prev_bus = code_bus;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int r0, f0;
    cyc(5);
    rst = 1'b0;
    cyc(2);
    // R11 reset state
    chk("R11 early_steer after reset", {3'b0, early_steer}, 4'd0);
    chk("R11 delayed_steer after reset", {3'b0, delayed_steer}, 4'd0);
    chk("R11 code after reset", code_bus, 4'd0);

    // R6 / R3 / R5: all sixteen pairs through the table
    foreach (VEC[i]) begin
      press(VEC[i][7:6], VEC[i][5:4], 40);
      chk("R1 early_steer during tone", {3'b0, early_steer}, 4'd1);
      chk("R3 long tone accepted", {3'b0, delayed_steer}, 4'd1);
      chk("R6 code map", code_bus, VEC[i][3:0]);
      release_for(45);
      chk("R5 long gap releases", {3'b0, delayed_steer}, 4'd0);
      chk("R7 code held after release", code_bus, VEC[i][3:0]);
    end

    // R1: early flag drops on loss of tone
    press(2'd1, 2'd1, 5);
    chk("R1 early_steer rises", {3'b0, early_steer}, 4'd1);
    tone_valid = 1'b0;
    cyc(1);
    chk("R1 early_steer drops", {3'b0, early_steer}, 4'd0);
    release_for(45);

    // R8: latched code 0000, bus floats to pull-up value
    oe = 1'b0; cyc(1);
    chk("R8 bus floats with oe low", code_bus, 4'hF);
    oe = 1'b1; cyc(1);
    chk("R8 bus driven with oe high", code_bus, 4'h0);

    // R3: short tone rejected
    r0 = rises;
    press(2'd1, 2'd1, 20);
    release_for(45);
    chk("R3 short tone no flag", 4'(rises - r0), 4'd0);
    chk("R3 short tone latch kept", code_bus, 4'd0);

    // R2: 35 ms tone is registered
    press(2'd0, 2'd1, 35);
    release_for(5);
    chk("R2 35ms tone registered", code_bus, 4'd2);
    release_for(40);

    // R4: short gap bridged, second key ignored
    f0 = falls;
    press(2'd0, 2'd0, 40);
    release_for(10);
    press(2'd2, 2'd2, 40);
    chk("R4 flag held across short gap", {3'b0, delayed_steer}, 4'd1);
    chk("R4 no fall across short gap", 4'(falls - f0), 4'd0);
    chk("R4 latch not rewritten", code_bus, 4'd1);
    release_for(45);
    chk("R5 flag low after long gap", {3'b0, delayed_steer}, 4'd0);
    press(2'd2, 2'd2, 40);
    chk("R5 new tone accepted", code_bus, 4'd9);
    release_for(45);

    // R9: inhibit
    inhibit = 1'b1;
    press(2'd0, 2'd2, 50);
    chk("R9 early_steer low under inhibit", {3'b0, early_steer}, 4'd0);
    chk("R9 no flag under inhibit", {3'b0, delayed_steer}, 4'd0);
    chk("R9 latch kept under inhibit", code_bus, 4'd9);
    tone_valid = 1'b0; inhibit = 1'b0;
    ms(45);

    // R10: power-down
    press(2'd2, 2'd0, 40);
    chk("R10 setup flag", {3'b0, delayed_steer}, 4'd1);
    pwrdn = 1'b1;
    cyc(2);
    chk("R10 flags cleared", {2'b0, early_steer, delayed_steer}, 4'd0);
    chk("R10 code kept", code_bus, 4'd7);
    ms(10);
    pwrdn = 1'b0;
    ms(10);
    chk("R10 timer restarted", {3'b0, delayed_steer}, 4'd0);
    ms(30);
    chk("R10 re-registered after release", {3'b0, delayed_steer}, 4'd1);
    release_for(45);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule